// File: doc/BRIEF.md
# Serial Feedback Divider Programming Interface

This block is the digital control side of a clock synthesizer that supports frequency margining. A three-wire serial port (serial clock, serial data, load enable) loads a 6-bit feedback divider value. While the load enable is high, each rising edge of the serial clock shifts one data bit into a 6-bit shift register, most significant bit first. When the load enable falls, the shift register contents are copied into a divider control register.

A mode input picks the divider value that reaches the PLL. With the mode low (nominal), the output is the hard-wired value 50, which yields 100 MHz from a 12 MHz reference through a divide-by-6 output stage. With the mode high (margining), the output is the programmed control value. Dropping back to nominal always restores 50, and the programmed value is kept for the next return to margining. A flag reports whether the selected value lies in the supported margining span of 45 to 55. Each step of 1 moves the output by 2 MHz.

All serial pins and the mode pin are asynchronous to the system clock. They are synchronized and edge-detected, so the block runs on one clock. An output change follows its pin change by a few system clock cycles.

Top module: `fdiv_prog_ctrl`

## Requirements
- R1: After reset, the divider output is 50 (binary 110010) and the in-range flag is 1, with the mode input either low or high, because the control register resets to 50.
- R2: While the load enable is high, each rising serial clock edge shifts the serial data bit into bit 0 of the shift register, and the older bits move one place toward bit 5. After six edges, the first bit sent sits in bit 5.
- R3: While the load enable is low, serial clock and serial data activity leaves the shift register unchanged.
- R4: The control register changes only on a high-to-low transition of the load enable, and it then takes the shift register contents. While the load enable stays high, the output keeps its previous value.
- R5: With the mode input low, the divider output is 50 whatever value was programmed.
- R6: A load done while the mode input is low is kept, and it appears on the output once the mode input goes high.
- R7: The in-range flag is 1 exactly when the output value is from 45 to 55 inclusive. A value outside that span still appears unchanged on the output.
- R8: A load with fewer than six serial clock edges still commits. The committed value is the previous shift register contents moved up by the number of bits received, with the new bits at the bottom.
- R9: Going from margining to nominal mode restores 50 on the output, and going back to margining shows the programmed value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_ld | input | 1 | Load enable; high to shift, falling edge commits |
| margin_mode | input | 1 | 1 = margining (programmed value), 0 = nominal (50) |
| div_sel | output | 6 | Selected feedback divider value |
| div_in_range | output | 1 | 1 when div_sel is within 45..55 |

## Verification
The bench targets the boundary values 44, 45, 55 and 56. A flag built with an off-by-one comparison would misreport one of them. It toggles the serial clock and data while the load enable is low, and then commits with no edges. A design that shifts without the enable would commit altered bits. It checks the output while the load enable is still high, where a design that commits early would already show the new value. Short loads, loads made in nominal mode and mode round trips are also covered: a design that lost stale bits, reset the register on a mode change or latched on the wrong edge would show a divider value other than the one the bench's own shift model predicts.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int DIV_W_DEF   = 6;
  localparam int NOMINAL_DEF = 50;
  localparam int SPAN_LO_DEF = 45;
  localparam int SPAN_HI_DEF = 55;
  localparam int SYNC_DEF    = 2;

  // channel positions inside the synchronizer vector
  typedef enum int {
    CH_SCLK = 0,
    CH_SDAT = 1,
    CH_LOAD = 2,
    CH_MODE = 3
  } sync_ch_e;

  localparam int SYNC_CH = 4;
endpackage

// File: rtl/fdiv_sync.sv
module fdiv_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_d
);
  localparam int ST = (STAGES < 2) ? 2 : STAGES;

  logic [ST-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '0;
      q_d <= '0;
    end else begin
      stg <= {stg[ST-2:0], d};
      q_d <= stg[ST-1];
    end
  end

  assign q = stg[ST-1];
endmodule

// File: rtl/fdiv_shifter.sv
module fdiv_shifter #(
  parameter int W       = 6,
  parameter int RST_VAL = 50
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_evt,
  input  logic         bit_in,
  input  logic         commit_evt,
  output logic [W-1:0] shreg,
  output logic [W-1:0] ctrl
);
  localparam logic [W-1:0] RST_V = W'(RST_VAL);

  function automatic logic [W-1:0] push_bit(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= RST_V;
    end else if (shift_evt) begin
      shreg <= push_bit(shreg, bit_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= RST_V;
    end else if (commit_evt) begin
      ctrl <= shreg;
    end
  end

  AST_SHIFT_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> (shreg[W-1:1] == $past(shreg[W-2:0])) && (shreg[0] == $past(bit_in))); // R2
  AST_SHREG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(shreg)); // R3
  AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> ctrl == $past(shreg)); // R4
  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(ctrl)); // R4
endmodule

// File: rtl/fdiv_select.sv
module fdiv_select #(
  parameter int W       = 6,
  parameter int NOMINAL = 50,
  parameter int SPAN_LO = 45,
  parameter int SPAN_HI = 55
) (
  input  logic         mode,
  input  logic [W-1:0] ctrl,
  output logic [W-1:0] div_sel,
  output logic         in_range
);
  localparam logic [W-1:0] NOM_V = W'(NOMINAL);
  localparam logic [W-1:0] LO_V  = W'(SPAN_LO);
  localparam logic [W-1:0] HI_V  = W'(SPAN_HI);

  function automatic logic in_span(input logic [W-1:0] v);
    return (v >= LO_V) && (v <= HI_V);
  endfunction

  always_comb begin
    div_sel  = mode ? ctrl : NOM_V;
    in_range = in_span(div_sel);
  end
endmodule

// File: rtl/fdiv_prog_ctrl.sv
module fdiv_prog_ctrl
  import fdiv_pkg::*;
#(
  parameter int DIV_W   = DIV_W_DEF,
  parameter int NOMINAL = NOMINAL_DEF,
  parameter int SPAN_LO = SPAN_LO_DEF,
  parameter int SPAN_HI = SPAN_HI_DEF,
  parameter int SYNC_ST = SYNC_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_ld,
  input  logic             margin_mode,
  output logic [DIV_W-1:0] div_sel,
  output logic             div_in_range
);
  localparam logic [DIV_W-1:0] NOM_V = DIV_W'(NOMINAL);

  logic [SYNC_CH-1:0] pin_vec, pin_s, pin_sd;

  always_comb begin
    pin_vec          = '0;
    pin_vec[CH_SCLK] = ser_clk;
    pin_vec[CH_SDAT] = ser_dat;
    pin_vec[CH_LOAD] = ser_ld;
    pin_vec[CH_MODE] = margin_mode;
  end

  fdiv_sync #(.WIDTH(SYNC_CH), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_vec), .q(pin_s), .q_d(pin_sd)
  );

  // named events for the checks
  logic sclk_rise, load_on, shift_evt, load_fall, mode_s;
  assign sclk_rise = pin_s[CH_SCLK] & ~pin_sd[CH_SCLK];
  assign load_on   = pin_s[CH_LOAD];
  assign shift_evt = sclk_rise & load_on;
  assign load_fall = ~pin_s[CH_LOAD] & pin_sd[CH_LOAD];
  assign mode_s    = pin_s[CH_MODE];

  logic [DIV_W-1:0] shreg, ctrl;

  fdiv_shifter #(.W(DIV_W), .RST_VAL(NOMINAL)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_evt(shift_evt), .bit_in(pin_s[CH_SDAT]),
    .commit_evt(load_fall), .shreg(shreg), .ctrl(ctrl)
  );

  fdiv_select #(.W(DIV_W), .NOMINAL(NOMINAL), .SPAN_LO(SPAN_LO), .SPAN_HI(SPAN_HI)) u_sel (
    .mode(mode_s), .ctrl(ctrl), .div_sel(div_sel), .in_range(div_in_range)
  );

  AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_evt, load_fall})); // R4
  AST_NOMINAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |-> (div_sel == NOM_V) && div_in_range); // R5
  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_s) |-> div_sel == NOM_V); // R9
  AST_MARGIN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_s |-> div_sel == ctrl); // R7
endmodule

// File: tb/test_fdiv_prog_ctrl.sv
module test_fdiv_prog_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0, margin_mode = 1'b0;
  logic [5:0] div_sel;
  logic div_in_range;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [5:0] m_sh = 6'd50;
  logic [5:0] m_ctrl = 6'd50;

  always #2.5 clk = ~clk;

  fdiv_prog_ctrl i_fdiv_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_ld(ser_ld), .margin_mode(margin_mode),
    .div_sel(div_sel), .div_in_range(div_in_range)
  );

  function automatic logic span_ok(input int v);
    return (v > 44) && (v < 56);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic check_out(input string req);
    int e;
    @(negedge clk);
    e = margin_mode ? int'(m_ctrl) : 50;
    chk(req, div_sel, e);
    chk({req, " flag"}, div_in_range, span_ok(e));
  endtask

  // load n bits taken MSB-first from val
  task automatic load(input logic [5:0] val, input int n, input logic md);
    margin_mode = md;
    ser_ld = 1'b1;
    tick(4);
    for (int i = 0; i < n; i++) begin
      ser_dat = val[5-i];
      tick(4);
      ser_clk = 1'b1;
      tick(4);
      ser_clk = 1'b0;
      m_sh = {m_sh[4:0], val[5-i]};
    end
    tick(6);
    check_out("R4 hold while load high");
    ser_ld = 1'b0;
    tick(6);
    m_ctrl = m_sh;
  endtask

  task automatic noise(input int k);
    for (int i = 0; i < k; i++) begin
      ser_dat = $urandom_range(0, 1);
      tick(3);
      ser_clk = 1'b1;
      tick(3);
      ser_clk = 1'b0;
    end
  endtask

  initial begin
    void'($urandom(32'd7321));
    tick(5);
    rst_n = 1'b1;
    tick(6);
    check_out("R1 reset nominal");
    margin_mode = 1'b1;
    tick(6);
    check_out("R1 reset margin");

    load(6'd53, 6, 1'b1);
    check_out("R2 msb first 53");
    margin_mode = 1'b0; tick(6);
    check_out("R9 exit to nominal");
    check_out("R5 nominal forced");
    margin_mode = 1'b1; tick(6);
    check_out("R9 back to margin");

    noise(5);
    load(6'd0, 0, 1'b1);
    check_out("R3 ignored while load low");

    load(6'd45, 6, 1'b0);
    check_out("R6 loaded in nominal, R5");
    margin_mode = 1'b1; tick(6);
    check_out("R6 shown in margin");

    load(6'd44, 6, 1'b1); check_out("R7 value 44");
    load(6'd55, 6, 1'b1); check_out("R7 value 55");
    load(6'd56, 6, 1'b1); check_out("R7 value 56");
    load(6'd63, 6, 1'b1); check_out("R7 value 63");

    load(6'b101000, 3, 1'b1);
    check_out("R8 short load 3");
    load(6'b100000, 1, 1'b1);
    check_out("R8 short load 1");

    for (int it = 0; it < 60; it++) begin
      logic [5:0] v;
      int n;
      v = 6'($urandom_range(0, 63));
      n = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 5)) : 6;
      if ($urandom_range(0, 2) == 0) noise(int'($urandom_range(1, 4)));
      load(v, n, 1'($urandom_range(0, 1)));
      margin_mode = 1'($urandom_range(0, 1));
      tick(6);
      check_out(n == 6 ? "R2 random load" : "R8 random short load");
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired got=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule